// File: doc/BRIEF.md
# I2C Pointer-Register Slave

This block is the serial front end of a small peripheral whose four 16-bit registers sit behind a pointer. It oversamples SCL and SDA on the system clock and detects START, repeated START and STOP. It responds to a 7-bit address. The upper four bits of that address are fixed at `1001`. The lower three bits come from strap pins, which are captured once, at the first START after reset. The block pulls SDA low through an open-drain enable (`sda_oe` high means the line is driven low).

A write transaction always carries the pointer in its first byte. Any further bytes go out on a valid/ready write stream, high half first, then low half, then high again, and so on. Each beat carries the register index and a half flag. `wr_valid` stays high, with its fields held, until the sink raises `wr_ready`. The bus cannot be stretched, so the sink must take each beat before the next byte finishes. That gives it at least nine SCL periods. If the sink is too slow, a newer beat replaces the pending one.

A read transaction returns the register the pointer selects. The block shows that index on `rd_sel` and samples `rd_data` at each byte load, sending the most significant byte first. The pointer keeps its value until a later write changes it.

Top module: `i2c_ptr_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins an address phase from any state, including in the middle of a transfer (repeated START). A STOP (SDA rises while SCL is high) returns the block to idle.
- R2: An address byte whose upper seven bits equal `1001` followed by the latched strap value is acknowledged, with `sda_oe` high during the ninth SCL pulse. For any other address, SDA is not driven until the next START.
- R3: The strap value is captured at the first START after reset. Later changes on `strap_i` do not change the matched address.
- R4: In a write, the first byte after the address loads the pointer and is acknowledged. `rd_sel` then shows pointer bits [1:0].
- R5: Each later write byte is acknowledged and emitted as one write beat to register `wr_sel`. The beat after a pointer byte has `wr_hi`=1 (bits 15:8), and the half then alternates with each byte.
- R6: A write carrying only the pointer is legal. The pointer keeps its value across any number of reads.
- R7: A read sends `rd_data[15:8]` and then `rd_data[7:0]`, each most significant bit first. It keeps alternating the two halves while the master acknowledges.
- R8: When the master does not acknowledge a read byte, the block releases SDA and does not drive it again until the next START.
- R9: `wr_valid` stays high until `wr_ready` is high at a clock edge, and then drops.
- R10: `sda_oe` rises only while the sampled SCL is low.
- R11: After reset, `sda_oe`=0, `wr_valid`=0 and `rd_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls SDA low |
| strap_i | input | 3 | Low address bits from the strap pins |
| rd_sel | output | 2 | Register index chosen by the pointer |
| rd_data | input | 16 | Contents of the register at `rd_sel` |
| wr_valid | output | 1 | Write beat available |
| wr_ready | input | 1 | Sink accepts the beat |
| wr_sel | output | 2 | Register index of the beat |
| wr_hi | output | 1 | 1: bits 15:8, 0: bits 7:0 |
| wr_data | output | 8 | Byte to store |

## Verification
The hardest case to reach from the ports is the strap latch. Its state is invisible, and only a later address match, after the strap pins have moved, can show it. For every strap value the bench resets the block, issues one START, flips every strap bit, and then probes all eight addresses. Only the value present at that first START may be acknowledged. The same sweep also runs pointer-only writes, repeated-START reads and NACK-terminated reads. All expected bytes are computed from the strap value and the pointer.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;
  localparam int NREG   = 4;
  localparam int SEL_W  = $clog2(NREG);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } link_st_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_PTR,
    RL_DATA
  } byte_role_e;

  typedef struct packed {
    logic              hi;
    logic [BYTE_W-1:0] data;
  } wr_beat_t;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic            scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_p <= scl_q[SYNC-1];
      sda_p <= sda_q[SYNC-1];
    end
  end

  assign scl_s     = scl_q[SYNC-1];
  assign sda_s     = sda_q[SYNC-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_p & scl_s & sda_p & ~sda_s;
  assign stop_det  = scl_p & scl_s & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_strap_latch.sv
module i2c_strap_latch #(
  parameter int STRAP_W  = 3,
  parameter bit ON_START = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_det,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] addr_lo
);
  logic               done_q;
  logic [STRAP_W-1:0] lat_q;
  logic               take;

  generate
    if (ON_START) begin : g_on_start
      assign take = start_det;
    end else begin : g_on_reset
      assign take = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      lat_q  <= '0;
    end else if (!done_q && take) begin
      done_q <= 1'b1;
      lat_q  <= strap_i;
    end
  end

  assign addr_lo = done_q ? lat_q : strap_i;

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> $stable(addr_lo));
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import i2c_ptr_pkg::*;
#(
  parameter int           STRAP_W = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI = 4'b1001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] addr_lo,
  input  logic [REG_W-1:0]   rd_data,
  input  logic               wr_ready,
  output logic               sda_oe,
  output logic [SEL_W-1:0]   ptr,
  output logic               wr_valid,
  output wr_beat_t           wr_beat
);
  link_st_e          st_q;
  byte_role_e        role_q;
  logic [3:0]        bcnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] txs_q;
  logic [BYTE_W-1:0] lo_q;
  logic              rw_q;
  logic              half_q;
  logic              tx_lo_q;
  logic              mack_q;
  logic              oe_q;
  logic              wv_q;
  logic [SEL_W-1:0]  ptr_q;
  wr_beat_t          beat_q;
  logic [BYTE_W-1:0] nxt_byte;

  assign nxt_byte = tx_lo_q ? rd_data[REG_W-1 -: BYTE_W] : lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      role_q  <= RL_ADDR;
      bcnt_q  <= '0;
      sh_q    <= '0;
      txs_q   <= '0;
      lo_q    <= '0;
      rw_q    <= 1'b0;
      half_q  <= 1'b0;
      tx_lo_q <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wv_q    <= 1'b0;
      ptr_q   <= '0;
      beat_q  <= '0;
    end else begin
      if (wv_q && wr_ready) wv_q <= 1'b0;
      if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_det) begin
        st_q   <= ST_RX;
        role_q <= RL_ADDR;
        bcnt_q <= '0;
        oe_q   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise && bcnt_q != 4'd8) begin
              sh_q   <= {sh_q[BYTE_W-2:0], sda_s};
              bcnt_q <= bcnt_q + 4'd1;
            end else if (scl_fall && bcnt_q == 4'd8) begin
              case (role_q)
                RL_ADDR: begin
                  if (sh_q[BYTE_W-1:1] == {ADDR_HI, addr_lo}) begin
                    rw_q <= sh_q[0];
                    oe_q <= 1'b1;
                    st_q <= ST_ACK;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                RL_PTR: begin
                  ptr_q  <= sh_q[SEL_W-1:0];
                  half_q <= 1'b0;
                  oe_q   <= 1'b1;
                  st_q   <= ST_ACK;
                end
                default: begin
                  beat_q <= '{hi: ~half_q, data: sh_q};
                  wv_q   <= 1'b1;
                  half_q <= ~half_q;
                  oe_q   <= 1'b1;
                  st_q   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bcnt_q <= '0;
              if (role_q == RL_ADDR && rw_q) begin
                txs_q   <= rd_data[REG_W-1 -: BYTE_W];
                lo_q    <= rd_data[BYTE_W-1:0];
                tx_lo_q <= 1'b0;
                oe_q    <= ~rd_data[REG_W-1];
                st_q    <= ST_TX;
              end else begin
                oe_q   <= 1'b0;
                role_q <= (role_q == RL_ADDR) ? RL_PTR : RL_DATA;
                st_q   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt_q == 4'd7) begin
                oe_q <= 1'b0;
                st_q <= ST_TXACK;
              end else begin
                txs_q  <= {txs_q[BYTE_W-2:0], 1'b0};
                oe_q   <= ~txs_q[BYTE_W-2];
                bcnt_q <= bcnt_q + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                if (tx_lo_q) lo_q <= rd_data[BYTE_W-1:0];
                txs_q   <= nxt_byte;
                oe_q    <= ~nxt_byte[BYTE_W-1];
                tx_lo_q <= ~tx_lo_q;
                bcnt_q  <= '0;
                st_q    <= ST_TX;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = oe_q;
  assign ptr      = ptr_q;
  assign wr_valid = wv_q;
  assign wr_beat  = beat_q;

  // R10
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_q && !wr_ready) |=> wv_q);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);

  // R4
  ptr_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> $past(scl_fall));
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2c_ptr_pkg::*;
#(
  parameter int           SYNC     = 2,
  parameter int           STRAP_W  = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI = 4'b1001,
  parameter bit           ON_START = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [SEL_W-1:0]   rd_sel,
  input  logic [REG_W-1:0]   rd_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [SEL_W-1:0]   wr_sel,
  output logic               wr_hi,
  output logic [BYTE_W-1:0]  wr_data
);
  logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [STRAP_W-1:0] addr_lo;
  logic [SEL_W-1:0]   ptr;
  wr_beat_t           beat;

  i2c_bus_sampler #(.SYNC(SYNC)) i_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_strap_latch #(.STRAP_W(STRAP_W), .ON_START(ON_START)) i_strap (
    .clk(clk), .rst_n(rst_n), .start_det(start_det),
    .strap_i(strap_i), .addr_lo(addr_lo)
  );

  i2c_link_fsm #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) i_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .addr_lo(addr_lo),
    .rd_data(rd_data), .wr_ready(wr_ready), .sda_oe(sda_oe),
    .ptr(ptr), .wr_valid(wr_valid), .wr_beat(beat)
  );

  assign rd_sel  = ptr;
  assign wr_sel  = ptr;
  assign wr_hi   = beat.hi;
  assign wr_data = beat.data;
endmodule

// File: tb/test_i2c_ptr_slave.sv
module test_i2c_ptr_slave;
  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        bus_sda;
  logic        sda_oe;
  logic [2:0]  strap = 3'd0;
  logic [1:0]  rd_sel, wr_sel;
  logic [15:0] rd_data;
  logic        wr_valid, wr_ready = 1'b1, wr_hi;
  logic [7:0]  wr_data;
  logic [15:0] mem [4];
  logic [15:0] expv [4];
  int          checks = 0, errors = 0, bad_oe = 0;
  logic        oe_p = 1'b0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  assign bus_sda = m_sda & ~sda_oe;
  assign rd_data = mem[rd_sel];

  i2c_ptr_slave i_i2c_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_oe(sda_oe), .strap_i(strap), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel),
    .wr_hi(wr_hi), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      if (wr_hi) mem[wr_sel][15:8] <= wr_data;
      else       mem[wr_sel][7:0]  <= wr_data;
    end
    if (rst_n && sda_oe && !oe_p && m_scl) bad_oe <= bad_oe + 1;
    oe_p <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    w(4);
    rst_n = 1'b1;
    w(4);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b0; w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b1; w(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q);
      m_scl = 1'b1; w(2*Q);
      m_scl = 1'b0; w(Q);
    end
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    ack = ~bus_sda; w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic rbyte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; w(Q);
      m_scl = 1'b1; w(Q);
      b[i] = bus_sda; w(Q);
      m_scl = 1'b0; w(Q);
    end
    m_sda = ~mack; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_scl = 1'b0; w(Q);
    m_sda = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    i2c_start();
    wbyte({4'b1001, strap_latched, 1'b0}, a);
    chk(a, "R4 addr ack", a, 1);
    wbyte(p, a);
    chk(a, "R4 ptr ack", a, 1);
    i2c_stop();
    chk(rd_sel == p[1:0], "R4 rd_sel", rd_sel, p[1:0]);
  endtask

  logic [2:0] strap_latched;

  initial begin
    logic a;
    logic [7:0] b0, b1, b2, b3;
    logic [7:0] hi, lo;
    for (int k = 0; k < 4; k++) mem[k] = 16'h0;
    do_reset();
    // R11 reset state
    chk(sda_oe == 1'b0, "R11 sda_oe", sda_oe, 0);
    chk(wr_valid == 1'b0, "R11 wr_valid", wr_valid, 0);
    chk(rd_sel == 2'd0, "R11 rd_sel", rd_sel, 0);

    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      do_reset();
      strap_latched = 3'(s);
      // first START latches straps, then the pins move (R3)
      i2c_start();
      strap = 3'(s) ^ 3'b111;
      i2c_stop();
      for (int ad = 0; ad < 8; ad++) begin
        i2c_start();
        wbyte({4'b1001, 3'(ad), 1'b0}, a);
        chk(a == (ad == s), "R2 R3 address match", a, ad == s);
        wbyte(8'(ad), a);
        chk(a == (ad == s), "R2 follow-on byte", a, ad == s);
        i2c_stop();
      end
      // writes to every register (R4, R5)
      for (int p = 0; p < 4; p++) begin
        hi = 8'h5A ^ 8'(s << 4) ^ 8'(p);
        lo = 8'hA5 + 8'(s * 3) + 8'(p * 17);
        expv[p] = {hi, lo};
        i2c_start();
        wbyte({4'b1001, strap_latched, 1'b0}, a);
        chk(a, "R2 write addr ack", a, 1);
        wbyte(8'(p + 4 * s), a);
        chk(a, "R4 ptr ack", a, 1);
        chk(rd_sel == 2'(p), "R4 rd_sel", rd_sel, p);
        wbyte(hi, a);
        chk(a, "R5 hi ack", a, 1);
        wbyte(lo, a);
        chk(a, "R5 lo ack", a, 1);
        i2c_stop();
        chk(mem[p] == expv[p], "R5 register contents", mem[p], expv[p]);
      end
      // pointer-only write then repeated reads (R6)
      set_ptr(8'(s % 4));
      for (int r = 0; r < 2; r++) begin
        i2c_start();
        wbyte({4'b1001, strap_latched, 1'b1}, a);
        chk(a, "R6 read addr ack", a, 1);
        rbyte(b0, 1'b1);
        rbyte(b1, 1'b0);
        i2c_stop();
        chk({b0, b1} == expv[s % 4], "R6 persistent pointer read", {b0, b1}, expv[s % 4]);
      end
      // long read alternates halves (R7)
      i2c_start();
      wbyte({4'b1001, strap_latched, 1'b1}, a);
      rbyte(b0, 1'b1); rbyte(b1, 1'b1); rbyte(b2, 1'b1); rbyte(b3, 1'b0);
      i2c_stop();
      chk({b0, b1, b2, b3} == {expv[s % 4], expv[s % 4]}, "R7 four-byte read",
          {b0, b1, b2, b3}, {expv[s % 4], expv[s % 4]});
      // pointer write then repeated START read (R1)
      i2c_start();
      wbyte({4'b1001, strap_latched, 1'b0}, a);
      wbyte(8'((s + 1) % 4), a);
      i2c_start();
      wbyte({4'b1001, strap_latched, 1'b1}, a);
      chk(a, "R1 repeated START addr ack", a, 1);
      rbyte(b0, 1'b1); rbyte(b1, 1'b0);
      i2c_stop();
      chk({b0, b1} == expv[(s + 1) % 4], "R1 repeated START read", {b0, b1}, expv[(s + 1) % 4]);
      // NACK ends the read (R8)
      i2c_start();
      wbyte({4'b1001, strap_latched, 1'b1}, a);
      rbyte(b0, 1'b0);
      rbyte(b1, 1'b0);
      i2c_stop();
      chk(b0 == expv[(s + 1) % 4][15:8], "R8 first byte", b0, expv[(s + 1) % 4][15:8]);
      chk(b1 == 8'hFF, "R8 released after NACK", b1, 8'hFF);
      // back-pressure on the write stream (R9)
      if (s == 0) begin
        wr_ready = 1'b0;
        i2c_start();
        wbyte({4'b1001, strap_latched, 1'b0}, a);
        wbyte(8'h02, a);
        wbyte(8'hC3, a);
        i2c_stop();
        w(20);
        chk(wr_valid == 1'b1, "R9 valid held", wr_valid, 1);
        chk({wr_sel, wr_hi, wr_data} == {2'd2, 1'b1, 8'hC3}, "R9 beat held",
            {wr_sel, wr_hi, wr_data}, {2'd2, 1'b1, 8'hC3});
        wr_ready = 1'b1;
        w(2);
        chk(wr_valid == 1'b0, "R9 valid drops", wr_valid, 0);
        chk(mem[2][15:8] == 8'hC3, "R9 beat stored", mem[2][15:8], 8'hC3);
        expv[2][15:8] = 8'hC3;
      end
    end
    chk(bad_oe == 0, "R10 sda_oe rise while SCL high", bad_oe, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule